// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns a 32-bit linear address into a 32-bit physical address by walking a two-level page table kept in memory. A caller offers a linear address, a paging-enable flag and a directory base value. When paging is on, the walker reads one directory entry and then one page-table entry over a word-read port. It then returns the frame number from the second entry joined to the untouched page offset.

When paging is off, the linear address comes back unchanged in the cycle after acceptance, and no memory read is made. A clear present bit in either entry ends the walk with a fault pulse and a zero address. Only one translation runs at a time. The caller watches `busy` and waits for a one-cycle `done` or `fault` pulse.

Top module: `page_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `memRdValid` are all low.
- R2: A request is accepted on a clock edge where `reqValid` is high and `busy` is low. `reqValid` and the request inputs are ignored while `busy` is high, so the running walk completes with its own operands.
- R3: If `pagingOn` is low at acceptance, `done` rises in the next cycle with `physAddr` equal to the accepted linear address, and no memory read is issued.
- R4: With paging on, the first read goes to address `{dirBase[31:12], 12'h000} + 4 * linear[31:22]`. The low 12 bits of `dirBase` have no effect.
- R5: If the directory entry has bit 0 (present) set, the second read goes to `{dirEntry[31:12], 12'h000} + 4 * linear[21:12]`.
- R6: If the page-table entry has bit 0 set, `done` pulses with `physAddr = {pte[31:12], linear[11:0]}`. Entry bits 11..1 have no effect on the result.
- R7: A clear bit 0 in either entry ends the walk with a one-cycle `fault` pulse and `physAddr` equal to zero. A directory fault issues no second read.
- R8: `busy` is high from the cycle after acceptance through the `done`/`fault` cycle and low in the next one. `done` and `fault` last one cycle and never occur together.
- R9: `memRdValid` holds, with a stable `memRdAddr`, until `memRdReady` is seen. No new read is raised while a read awaits its response.
- R10: A `memRspValid` pulse while no read is outstanding has no effect: no `done` or `fault` is produced, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqLinear | input | 32 | Linear address to translate |
| pagingOn | input | 1 | 1 = walk the tables, 0 = pass through |
| dirBase | input | 32 | Directory base; bits 31..12 are used |
| busy | output | 1 | A translation is in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle not-present pulse |
| physAddr | output | 32 | Result, valid with `done` (zero with `fault`) |
| memRdValid | output | 1 | Word read request |
| memRdAddr | output | 32 | Byte address of the word read |
| memRdReady | input | 1 | Memory accepts the read |
| memRspValid | input | 1 | Read data is valid |
| memRspData | input | 32 | Read data word |

## Verification
The bench targets a pass-through that still touches memory or takes extra cycles, and a directory base whose low bits leak into the entry address. It also covers a walk that keeps going after a not-present directory entry, and attribute bits of an entry that reach the frame number. Memory stalls on both the request and response sides expose a request address that drifts or a response that is taken too early. A second request raised during a walk would corrupt the result if it were not ignored. A response pulse while idle would cause a false completion if it were not ignored.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_PTE_REQ,
    ST_PTE_WAIT,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;     // capture request operands
    logic passLinear;  // result is the linear address itself
    logic loadTable;   // capture page-table frame from directory entry
    logic loadFrame;   // capture final frame and build result
    logic selTable;    // read address selects the page-table entry
  } walkStrobe_t;

endpackage

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DIR_W       = 10,
  parameter int TBL_W       = 10,
  parameter int OFF_W       = 12,
  parameter int PRESENT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqLinear,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] physAddr,
  output logic              entryPresent
);

  localparam int FRAME_W     = ADDR_W - OFF_W;
  localparam int ENTRY_SHIFT = 2;

  logic [ADDR_W-1:0]  linReg;
  logic [FRAME_W-1:0] dirFrame;
  logic [FRAME_W-1:0] tblFrame;
  logic [ADDR_W-1:0]  physReg;

  logic [DIR_W-1:0]  dirIdx;
  logic [TBL_W-1:0]  tblIdx;
  logic [ADDR_W-1:0] dirEntryAddr;
  logic [ADDR_W-1:0] tblEntryAddr;

  assign dirIdx = linReg[ADDR_W-1 -: DIR_W];
  assign tblIdx = linReg[OFF_W +: TBL_W];

  assign dirEntryAddr = {dirFrame, {OFF_W{1'b0}}}
                      + ({{(ADDR_W-DIR_W){1'b0}}, dirIdx} << ENTRY_SHIFT);
  assign tblEntryAddr = {tblFrame, {OFF_W{1'b0}}}
                      + ({{(ADDR_W-TBL_W){1'b0}}, tblIdx} << ENTRY_SHIFT);

  assign memRdAddr    = strobe.selTable ? tblEntryAddr : dirEntryAddr;
  assign entryPresent = memRspData[PRESENT_BIT];
  assign physAddr     = physReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      linReg   <= '0;
      dirFrame <= '0;
      tblFrame <= '0;
      physReg  <= '0;
    end else begin
      if (strobe.loadReq) begin
        linReg   <= reqLinear;
        dirFrame <= dirBase[ADDR_W-1:OFF_W];
        physReg  <= strobe.passLinear ? reqLinear : '0;
      end
      if (strobe.loadTable) begin
        tblFrame <= memRspData[ADDR_W-1:OFF_W];
      end
      if (strobe.loadFrame) begin
        physReg <= {memRspData[ADDR_W-1:OFF_W], linReg[OFF_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        pagingOn,
  input  logic        memRdReady,
  input  logic        memRspValid,
  input  logic        entryPresent,
  output walkStrobe_t strobe,
  output logic        memRdValid,
  output logic        busy,
  output logic        done,
  output logic        fault
);

  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    memRdValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadReq    = 1'b1;
          strobe.passLinear = !pagingOn;
          stateNext         = pagingOn ? ST_DIR_REQ : ST_DONE;
        end
      end
      ST_DIR_REQ: begin
        memRdValid = 1'b1;
        if (memRdReady) stateNext = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        if (memRspValid) begin
          if (entryPresent) begin
            strobe.loadTable = 1'b1;
            stateNext        = ST_PTE_REQ;
          end else begin
            stateNext = ST_FAULT;
          end
        end
      end
      ST_PTE_REQ: begin
        memRdValid      = 1'b1;
        strobe.selTable = 1'b1;
        if (memRdReady) stateNext = ST_PTE_WAIT;
      end
      ST_PTE_WAIT: begin
        strobe.selTable = 1'b1;
        if (memRspValid) begin
          if (entryPresent) begin
            strobe.loadFrame = 1'b1;
            stateNext        = ST_DONE;
          end else begin
            stateNext = ST_FAULT;
          end
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign busy  = (state != ST_IDLE);
  assign done  = (state == ST_DONE);
  assign fault = (state == ST_FAULT);

endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIR_W  = 10,
  parameter int TBL_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqLinear,
  input  logic              pagingOn,
  input  logic [ADDR_W-1:0] dirBase,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] physAddr,
  output logic              memRdValid,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdReady,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData
);

  walkStrobe_t strobe;
  logic        entryPresent;

  pw_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqValid     (reqValid),
    .pagingOn     (pagingOn),
    .memRdReady   (memRdReady),
    .memRspValid  (memRspValid),
    .entryPresent (entryPresent),
    .strobe       (strobe),
    .memRdValid   (memRdValid),
    .busy         (busy),
    .done         (done),
    .fault        (fault)
  );

  pw_datapath #(
    .ADDR_W (ADDR_W),
    .DIR_W  (DIR_W),
    .TBL_W  (TBL_W),
    .OFF_W  (OFF_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .reqLinear    (reqLinear),
    .dirBase      (dirBase),
    .memRspData   (memRspData),
    .memRdAddr    (memRdAddr),
    .physAddr     (physAddr),
    .entryPresent (entryPresent)
  );

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqLinear,
  input logic              pagingOn,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [ADDR_W-1:0] physAddr,
  input logic              memRdValid,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              memRdReady,
  input logic              memRspValid
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n)                        outstanding <= 1'b0;
    else if (memRdValid && memRdReady) outstanding <= 1'b1;
    else if (memRspValid)              outstanding <= 1'b0;
  end

  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !busy && !pagingOn) |=> (done && physAddr == $past(reqLinear)));

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (physAddr == '0));

  p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !busy);

  p_pulse_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> busy);

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (memRdValid && !memRdReady) |=> (memRdValid && $stable(memRdAddr)));

  p_one_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !memRdValid);

  p_ignore_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !fault) |=> busy);

endmodule

bind page_walker pw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .reqLinear   (reqLinear),
  .pagingOn    (pagingOn),
  .busy        (busy),
  .done        (done),
  .fault       (fault),
  .physAddr    (physAddr),
  .memRdValid  (memRdValid),
  .memRdAddr   (memRdAddr),
  .memRdReady  (memRdReady),
  .memRspValid (memRspValid)
);

// File: tb/tb_page_walker.sv
module tb_page_walker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reqValid;
  logic [31:0] reqLinear;
  logic        pagingOn;
  logic [31:0] dirBase;
  logic        busy, done, fault;
  logic [31:0] physAddr;
  logic        memRdValid;
  logic [31:0] memRdAddr;
  logic        memRdReady;
  logic        memRspValid;
  logic [31:0] memRspData;

  int checks = 0;
  int fails  = 0;

  // memory model state
  logic [31:0] memImg [logic [31:0]];
  int          readyLat = 0;
  int          rspLat   = 1;
  int          waitCnt  = 0;
  int          pend     = 0;
  logic [31:0] pendAddr;
  int          readCount = 0;
  logic [31:0] rdLog [0:3];
  bit          injectRsp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_walker dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqLinear(reqLinear),
    .pagingOn(pagingOn), .dirBase(dirBase), .busy(busy), .done(done),
    .fault(fault), .physAddr(physAddr), .memRdValid(memRdValid),
    .memRdAddr(memRdAddr), .memRdReady(memRdReady), .memRspValid(memRspValid),
    .memRspData(memRspData)
  );

  function automatic logic [31:0] lookup(input logic [31:0] a);
    return memImg.exists(a) ? memImg[a] : 32'h0;
  endfunction

  function automatic logic [31:0] dirAddrOf(input logic [31:0] base, input logic [31:0] lin);
    return {base[31:12], 12'h000} + {20'h0, lin[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] pteAddrOf(input logic [31:0] ent, input logic [31:0] lin);
    return {ent[31:12], 12'h000} + {20'h0, lin[21:12], 2'b00};
  endfunction

  // memory model: decides inputs at the falling edge for the next rising edge
  always @(negedge clk) begin
    memRspValid = 1'b0;
    memRspData  = 32'h0;
    if (injectRsp) begin
      memRspValid = 1'b1;
      memRspData  = 32'hFFFF_F001;
    end
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        memRspValid = 1'b1;
        memRspData  = lookup(pendAddr);
      end
    end
    memRdReady = 1'b0;
    if (rst_n && memRdValid) begin
      if (waitCnt < readyLat) begin
        waitCnt = waitCnt + 1;
      end else begin
        memRdReady = 1'b1;
        waitCnt    = 0;
        pendAddr   = memRdAddr;
        pend       = rspLat;
        if (readCount < 4) rdLog[readCount] = memRdAddr;
        readCount  = readCount + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one translation; optional poke raises a conflicting request mid-walk
  task automatic runWalk(input logic [31:0] lin, input logic pg, input logic [31:0] base,
                         input bit poke, output logic [31:0] ph, output logic flt,
                         output int cyc);
    int  guard;
    bit  busyOk;
    readCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqLinear = lin; pagingOn = pg; dirBase = base;
    @(negedge clk);
    reqValid = 1'b0; reqLinear = 32'hDEAD_BEEF; pagingOn = 1'b0; dirBase = 32'h0;
    cyc = 1; guard = 0; busyOk = 1;
    while (!(done || fault) && guard < 1000) begin
      if (!busy) busyOk = 0;
      if (poke && cyc == 2) reqValid = 1'b1;
      if (poke && cyc == 3) reqValid = 1'b0;
      @(negedge clk);
      cyc++; guard++;
    end
    reqValid = 1'b0;
    check("R8 busy during walk", {31'h0, busyOk & busy}, 32'h1);
    check("R8 done/fault exclusive", {31'h0, done & fault}, 32'h0);
    ph = physAddr; flt = fault;
    @(negedge clk);
    check("R8 busy low after pulse", {31'h0, busy}, 32'h0);
    check("R8 pulse one cycle", {30'h0, done, fault}, 32'h0);
  endtask

  task automatic test_reset();
    check("R1 busy", {31'h0, busy}, 32'h0);
    check("R1 done/fault", {30'h0, done, fault}, 32'h0);
    check("R1 memRdValid", {31'h0, memRdValid}, 32'h0);
  endtask

  task automatic test_bypass();
    logic [31:0] ph; logic flt; int cyc;
    runWalk(32'h89AB_CDEF, 1'b0, 32'h0001_0000, 0, ph, flt, cyc);
    check("R3 bypass addr", ph, 32'h89AB_CDEF);
    check("R3 bypass latency", cyc, 1);
    check("R3 bypass no reads", readCount, 0);
    check("R3 bypass no fault", {31'h0, flt}, 32'h0);
  endtask

  task automatic setupWalk(input logic [31:0] lin, input logic [31:0] base,
                           input logic [31:0] de, input logic [31:0] pte);
    memImg.delete();
    memImg[dirAddrOf(base, lin)] = de;
    memImg[pteAddrOf(de, lin)]   = pte;
  endtask

  task automatic test_basic_walk();
    logic [31:0] ph; logic flt; int cyc;
    logic [31:0] lin = 32'h1234_5678, base = 32'h0001_0000;
    logic [31:0] de = 32'h0002_0001, pte = 32'hABCD_E001;
    readyLat = 0; rspLat = 1;
    setupWalk(lin, base, de, pte);
    runWalk(lin, 1'b1, base, 0, ph, flt, cyc);
    check("R4 dir read addr", rdLog[0], dirAddrOf(base, lin));
    check("R5 pte read addr", rdLog[1], pteAddrOf(de, lin));
    check("R6 phys addr", ph, {pte[31:12], lin[11:0]});
    check("R6 two reads", readCount, 2);
  endtask

  task automatic test_stalled_poke();
    logic [31:0] ph; logic flt; int cyc;
    logic [31:0] lin = 32'hFFC0_1ABC, base = 32'h7FFF_F000;
    logic [31:0] de = 32'h0040_3001, pte = 32'h1357_9001;
    readyLat = 3; rspLat = 4;
    setupWalk(lin, base, de, pte);
    reqLinear = 32'h0; // poke drives reqValid with paging off and junk address
    runWalk(lin, 1'b1, base, 1, ph, flt, cyc);
    check("R9 stalled dir addr", rdLog[0], dirAddrOf(base, lin));
    check("R9 stalled pte addr", rdLog[1], pteAddrOf(de, lin));
    check("R2 poke ignored phys", ph, {pte[31:12], lin[11:0]});
    check("R2 poke ignored reads", readCount, 2);
    readyLat = 0; rspLat = 1;
  endtask

  task automatic test_low_bits_ignored();
    logic [31:0] ph; logic flt; int cyc;
    logic [31:0] lin = 32'h0000_3FFF, base = 32'h0005_0FFF;
    logic [31:0] de = 32'h0006_0FFF, pte = 32'h0BAD_0FFF;
    setupWalk(lin, base, de, pte);
    runWalk(lin, 1'b1, base, 0, ph, flt, cyc);
    check("R4 base low bits ignored", rdLog[0], {base[31:12], 12'h000});
    check("R5 entry attr bits ignored", rdLog[1], pteAddrOf(de, lin));
    check("R6 attr bits not in frame", ph, {pte[31:12], lin[11:0]});
  endtask

  task automatic test_dir_fault();
    logic [31:0] ph; logic flt; int cyc;
    logic [31:0] lin = 32'h4040_4040, base = 32'h0003_0000;
    memImg.delete();
    memImg[dirAddrOf(base, lin)] = 32'h0009_0FFE; // present clear
    runWalk(lin, 1'b1, base, 0, ph, flt, cyc);
    check("R7 dir fault flag", {31'h0, flt}, 32'h1);
    check("R7 dir fault phys zero", ph, 32'h0);
    check("R7 dir fault one read", readCount, 1);
  endtask

  task automatic test_pte_fault();
    logic [31:0] ph; logic flt; int cyc;
    logic [31:0] lin = 32'h0123_4567, base = 32'h0004_0000;
    logic [31:0] de = 32'h000A_0001;
    setupWalk(lin, base, de, 32'hFFFF_F000);
    rspLat = 2;
    runWalk(lin, 1'b1, base, 0, ph, flt, cyc);
    check("R7 pte fault flag", {31'h0, flt}, 32'h1);
    check("R7 pte fault phys zero", ph, 32'h0);
    check("R7 pte fault two reads", readCount, 2);
    rspLat = 1;
  endtask

  task automatic test_idle_response();
    int seen = 0;
    @(negedge clk);
    injectRsp = 1;
    @(negedge clk);
    injectRsp = 0;
    for (int i = 0; i < 3; i++) begin
      if (done || fault || busy) seen++;
      @(negedge clk);
    end
    check("R10 idle response ignored", seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reqValid = 1'b0; reqLinear = 32'h0; pagingOn = 1'b0; dirBase = 32'h0;
    memRdReady = 1'b0; memRspValid = 1'b0; memRspData = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_bypass();
    test_basic_walk();
    test_stalled_poke();
    test_low_bits_ignored();
    test_dir_fault();
    test_pte_fault();
    test_idle_response();
    test_bypass();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule